// File: doc/BRIEF.md
# Cipher Known-Answer Self-Test Wrapper

This block sits in front of one block-cipher core and makes every encryption request prove the core healthy first. When a request is accepted, the wrapper sends a fixed test plaintext and test key to the core and compares the returned block with a fixed expected ciphertext. Only when every bit agrees does it send the caller's plaintext and key through the same core. The caller's result is then released. On any disagreement the second run is skipped, the result is all zeros and a fail flag is raised.

The three test constants arrive on their own input ports, so synthesis cannot fold the comparison away. The caller's operands are captured when the request is accepted. A request therefore costs two core runs plus a few control cycles. A fault that appears only after the check has passed goes through on that request. A lasting fault shows up on the next request.

Top module: `kat_guarded_cipher`

## Requirements
- R1: After a synchronous reset, `res_valid`, `res_fail`, `core_go` are 0 and `res_text` is all zeros.
- R2: An accepted request first pulses `core_go` for one cycle with `core_text`/`core_key` equal to `tst_text`/`tst_key`. A passing request then pulses `core_go` exactly once more.
- R3: Both runs of a request use the one `core_*` port pair. The second run presents the user plaintext and key.
- R4: If the first run's result differs from `tst_expect` in any bit, there is no second `core_go`. `res_valid` rises with `res_text` all zeros and `res_fail` = 1.
- R5: On a pass, `res_text` equals the core result of the second run; each output bit is ANDed with the pass verdict.
- R6: With a core that raises `core_done` L cycles after the edge that samples `core_go`, let the accepting edge be n. `res_valid` is high in the cycle after edge n+2L+3 on a pass, and after edge n+L+2 on a fail.
- R7: `req_text`/`req_key` are captured at the accepting edge. Later changes do not alter the request.
- R8: `req_start` is accepted only while idle. A start seen while busy, including the cycle `res_valid` is high, is ignored.
- R9: `res_text` and `res_fail` hold their values after `res_valid` until the next accepted request, which clears both to 0.
- R10: `res_valid` is a single-cycle pulse per accepted request.
- R11: A fault that corrupts only the second run is passed to `res_text` with `res_fail` = 0. If the fault persists, the next request reports `res_fail` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, honoured only when idle |
| req_text | input | DATA_W | User plaintext |
| req_key | input | KEY_W | User key |
| res_text | output | DATA_W | Ciphertext, or zeros after a failed check |
| res_valid | output | 1 | One-cycle result pulse |
| res_fail | output | 1 | Self-test mismatch flag, held until the next request |
| tst_text | input | DATA_W | Known-answer plaintext |
| tst_key | input | KEY_W | Known-answer key |
| tst_expect | input | DATA_W | Known-answer expected ciphertext |
| core_go | output | 1 | Start pulse to the cipher core |
| core_text | output | DATA_W | Plaintext to the cipher core |
| core_key | output | KEY_W | Key to the cipher core |
| core_done | input | 1 | Core completion pulse |
| core_result | input | DATA_W | Core ciphertext |

## Verification
The bench builds the wrapper with its default 128-bit data and key widths and 8-bit compare lanes. It places a behavioural stand-in core behind it with a latency of three cycles. That core lets the bench inject XOR faults into either run and force a one-bit mismatch in the top lane or in the bottom lane. Busy-time starts, operand changes during a run and back-to-back starts all fall inside the exact cycle windows of R6.

// File: rtl/kat_pkg.sv
package kat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TEST_GO,
    ST_TEST_WAIT,
    ST_JUDGE,
    ST_USER_GO,
    ST_USER_WAIT,
    ST_DONE
  } kat_state_t;
endpackage

// File: rtl/kat_seq.sv
module kat_seq
  import kat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_start,
  input  logic       core_done,
  input  logic       match,
  output kat_state_t state,
  output logic       accept,
  output logic       core_go,
  output logic       use_test,
  output logic       take_test,
  output logic       judge,
  output logic       take_user,
  output logic       res_valid
);
  kat_state_t nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      if (req_start) nxt = ST_TEST_GO;
      ST_TEST_GO:   nxt = ST_TEST_WAIT;
      ST_TEST_WAIT: if (core_done) nxt = ST_JUDGE;
      ST_JUDGE:     nxt = match ? ST_USER_GO : ST_DONE;
      ST_USER_GO:   nxt = ST_USER_WAIT;
      ST_USER_WAIT: if (core_done) nxt = ST_DONE;
      ST_DONE:      nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  assign accept    = (state == ST_IDLE) && req_start;
  assign core_go   = (state == ST_TEST_GO) || (state == ST_USER_GO);
  assign use_test  = (state == ST_TEST_GO) || (state == ST_TEST_WAIT);
  assign take_test = (state == ST_TEST_WAIT) && core_done;
  assign judge     = (state == ST_JUDGE);
  assign take_user = (state == ST_USER_WAIT) && core_done;
  assign res_valid = (state == ST_DONE);

  p_go_single_r2: assert property (@(posedge clk) disable iff (rst)
    core_go |=> !core_go);

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (state != ST_TEST_GO));

  p_skip_on_mismatch_r4: assert property (@(posedge clk) disable iff (rst)
    (judge && !match) |=> (res_valid && !core_go));
endmodule

// File: rtl/kat_operand.sv
module kat_operand #(
  parameter int DATA_W = 128,
  parameter int KEY_W  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              use_test,
  input  logic [DATA_W-1:0] req_text,
  input  logic [KEY_W-1:0]  req_key,
  input  logic [DATA_W-1:0] tst_text,
  input  logic [KEY_W-1:0]  tst_key,
  output logic [DATA_W-1:0] core_text,
  output logic [KEY_W-1:0]  core_key
);
  logic [DATA_W-1:0] lat_text;
  logic [KEY_W-1:0]  lat_key;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_text <= '0;
      lat_key  <= '0;
    end else if (accept) begin
      lat_text <= req_text;
      lat_key  <= req_key;
    end
  end

  assign core_text = use_test ? tst_text : lat_text;
  assign core_key  = use_test ? tst_key  : lat_key;

  p_hold_operands_r7: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(lat_text) && $stable(lat_key)));
endmodule

// File: rtl/kat_verdict.sv
module kat_verdict #(
  parameter int DATA_W = 128,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              take_test,
  input  logic              judge,
  input  logic              take_user,
  input  logic [DATA_W-1:0] core_result,
  input  logic [DATA_W-1:0] tst_expect,
  output logic              match,
  output logic [DATA_W-1:0] res_text,
  output logic              res_fail
);
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] test_q;
  logic [LANES-1:0]  lane_ok;
  logic [DATA_W-1:0] gated;
  logic              pass_q;

  always_ff @(posedge clk) begin
    if (rst)            test_q <= '0;
    else if (take_test) test_q <= core_result;
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_ok[g] = (test_q[g*LANE_W +: LANE_W] == tst_expect[g*LANE_W +: LANE_W]);
    end
  endgenerate

  assign match = &lane_ok;

  genvar b;
  generate
    for (b = 0; b < DATA_W; b++) begin : g_gate
      assign gated[b] = core_result[b] & pass_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q   <= 1'b0;
      res_text <= '0;
      res_fail <= 1'b0;
    end else if (accept) begin
      pass_q   <= 1'b0;
      res_text <= '0;
      res_fail <= 1'b0;
    end else if (judge) begin
      pass_q   <= match;
      res_fail <= !match;
    end else if (take_user) begin
      res_text <= gated;
    end
  end

  p_fail_zeroes_r4: assert property (@(posedge clk) disable iff (rst)
    res_fail |-> (res_text == '0));

  p_user_after_pass_r5: assert property (@(posedge clk) disable iff (rst)
    take_user |-> pass_q);

  p_clear_on_accept_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!res_fail && (res_text == '0)));
endmodule

// File: rtl/kat_guarded_cipher.sv
module kat_guarded_cipher
  import kat_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int KEY_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic [DATA_W-1:0] req_text,
  input  logic [KEY_W-1:0]  req_key,
  output logic [DATA_W-1:0] res_text,
  output logic              res_valid,
  output logic              res_fail,
  input  logic [DATA_W-1:0] tst_text,
  input  logic [KEY_W-1:0]  tst_key,
  input  logic [DATA_W-1:0] tst_expect,
  output logic              core_go,
  output logic [DATA_W-1:0] core_text,
  output logic [KEY_W-1:0]  core_key,
  input  logic              core_done,
  input  logic [DATA_W-1:0] core_result
);
  kat_state_t state;
  logic accept, use_test, take_test, judge, take_user, match;

  kat_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_start (req_start),
    .core_done (core_done),
    .match     (match),
    .state     (state),
    .accept    (accept),
    .core_go   (core_go),
    .use_test  (use_test),
    .take_test (take_test),
    .judge     (judge),
    .take_user (take_user),
    .res_valid (res_valid)
  );

  kat_operand #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_operand (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .use_test  (use_test),
    .req_text  (req_text),
    .req_key   (req_key),
    .tst_text  (tst_text),
    .tst_key   (tst_key),
    .core_text (core_text),
    .core_key  (core_key)
  );

  kat_verdict #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_verdict (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .take_test   (take_test),
    .judge       (judge),
    .take_user   (take_user),
    .core_result (core_result),
    .tst_expect  (tst_expect),
    .match       (match),
    .res_text    (res_text),
    .res_fail    (res_fail)
  );

  p_done_while_running_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !core_go);
endmodule

// File: tb/kat_guarded_cipher_test.sv
module kat_guarded_cipher_test;
  localparam int DW       = 128;
  localparam int KW       = 128;
  localparam int CORE_LAT = 3;
  localparam int LIMIT    = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_start = 1'b0;
  logic [DW-1:0] req_text = '0;
  logic [KW-1:0] req_key = '0;
  logic [DW-1:0] res_text;
  logic          res_valid, res_fail;
  logic [DW-1:0] tst_text, tst_expect;
  logic [KW-1:0] tst_key;
  logic          core_go;
  logic [DW-1:0] core_text;
  logic [KW-1:0] core_key;
  logic          core_done = 1'b0;
  logic [DW-1:0] core_result;
  logic [DW-1:0] fault_mask = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  kat_guarded_cipher uut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_text(req_text), .req_key(req_key),
    .res_text(res_text), .res_valid(res_valid), .res_fail(res_fail),
    .tst_text(tst_text), .tst_key(tst_key), .tst_expect(tst_expect),
    .core_go(core_go), .core_text(core_text), .core_key(core_key),
    .core_done(core_done), .core_result(core_result)
  );

  function automatic logic [DW-1:0] ciph(input logic [DW-1:0] t, input logic [KW-1:0] k);
    logic [DW-1:0] x;
    x = t ^ k;
    for (int i = 0; i < 4; i++)
      x = ({x[DW-8:0], x[DW-1:DW-7]} ^ {k[63:0], k[127:64]}) + 128'h9e3779b97f4a7c15f39cc0605cedc834;
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // behavioural stand-in core: done L cycles after the edge that samples core_go
  logic [DW-1:0] cz_text = '0;
  logic [KW-1:0] cz_key = '0;
  int cz_cnt = 0;
  assign core_result = ciph(cz_text, cz_key) ^ fault_mask;

  always @(negedge clk) begin
    if (rst) begin
      cz_cnt = 0;
    end else if (core_go) begin
      cz_cnt  = CORE_LAT + 1;
      cz_text = core_text;
      cz_key  = core_key;
    end else if (cz_cnt > 0) begin
      cz_cnt--;
    end
    core_done = (cz_cnt == 1);
  end

  // reference model: request schedule decided at the sampling edge
  always @(posedge clk) cyc <= cyc + 1;

  bit            m_rst = 1'b1;
  bit            have = 1'b0;
  bit            m_pass = 1'b0;
  int            e0 = 0, vcyc = 0, idle_from = 0;
  logic [DW-1:0] m_text = '0;
  logic [KW-1:0] m_key = '0;

  always @(posedge clk) begin
    int n;
    n = cyc + 1;
    m_rst = rst;
    if (rst) begin
      have = 1'b0;
      idle_from = n + 1;
    end else if (req_start && n >= idle_from) begin
      e0     = n;
      m_text = req_text;
      m_key  = req_key;
      m_pass = ((ciph(tst_text, tst_key) ^ fault_mask) == tst_expect);
      vcyc   = m_pass ? n + 2*CORE_LAT + 3 : n + CORE_LAT + 2;
      idle_from = vcyc + 2;
      have   = 1'b1;
    end
  end

  logic [DW-1:0] ex_text = '0;
  bit            ex_fail = 1'b0;

  always @(negedge clk) begin
    bit ex_valid, ex_go;
    if (cyc >= 1 && !finished) begin
      if (m_rst) begin
        ex_text = '0; ex_fail = 1'b0; ex_valid = 1'b0; ex_go = 1'b0;
      end else begin
        if (have && cyc == e0) begin ex_text = '0; ex_fail = 1'b0; end
        if (have && cyc == vcyc) begin
          ex_fail = !m_pass;
          ex_text = m_pass ? (ciph(m_text, m_key) ^ fault_mask) : '0;
        end
        ex_valid = have && (cyc == vcyc);
        ex_go    = have && (cyc == e0 || (m_pass && cyc == e0 + CORE_LAT + 2));
        if (have && cyc == e0)
          chk(core_text == tst_text && core_key == tst_key, "R2 test operands", core_text, tst_text);
        if (have && m_pass && cyc == e0 + CORE_LAT + 2)
          chk(core_text == m_text && core_key == m_key, "R3 R7 user operands", core_text, m_text);
      end
      chk(res_valid == ex_valid, "R6 R10 valid timing", DW'(res_valid), DW'(ex_valid));
      chk(core_go == ex_go, "R2 R8 core start", DW'(core_go), DW'(ex_go));
      chk(res_text == ex_text, "R4 R5 R9 result", res_text, ex_text);
      chk(res_fail == ex_fail, "R4 R9 fail flag", DW'(res_fail), DW'(ex_fail));
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic request(input logic [DW-1:0] t, input logic [KW-1:0] k);
    req_text = t; req_key = k; req_start = 1'b1;
    tick();
    req_start = 1'b0;
  endtask

  task automatic wait_valid();
    while (!res_valid) tick();
  endtask

  task automatic summary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc >= LIMIT && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: no completion by cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    logic [DW-1:0] keep;
    int gos;
    tst_text   = 128'h00112233445566778899aabbccddeeff;
    tst_key    = 128'h000102030405060708090a0b0c0d0e0f;
    tst_expect = ciph(tst_text, tst_key);
    tick(4);
    rst = 1'b0;
    tick();
    chk(res_valid == 0 && res_fail == 0 && core_go == 0 && res_text == '0, "R1 reset state", res_text, '0);

    // plain passing request
    request(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c);
    wait_valid();
    chk(res_text == ciph(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c) && !res_fail,
        "R5 passing result", res_text, ciph(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c));
    tick(3);

    // operands change and a second start arrive while busy
    keep = 128'hdeadbeef0badf00dcafebabe12345678;
    request(keep, 128'h0f0e0d0c0b0a09080706050403020100);
    tick(2);
    req_text = ~keep; req_key = '1; req_start = 1'b1;
    tick();
    req_start = 1'b0;
    wait_valid();
    chk(res_text == ciph(keep, 128'h0f0e0d0c0b0a09080706050403020100), "R7 R8 latched operands", res_text,
        ciph(keep, 128'h0f0e0d0c0b0a09080706050403020100));
    tick(2);

    // permanent fault present during the self-test
    fault_mask = 128'h20;
    request(128'h1, 128'h2);
    wait_valid();
    chk(res_fail == 1 && res_text == '0, "R4 faulty core zeroes output", res_text, '0);
    fault_mask = '0;
    tick(4);
    chk(res_fail == 1 && res_text == '0, "R9 flag held after valid", DW'(res_fail), DW'(1));

    // one-bit mismatch in top lane of expected value
    tst_expect = ciph(tst_text, tst_key) ^ (128'h1 << 127);
    request(128'h55, 128'h66);
    wait_valid();
    chk(res_fail == 1, "R4 single bit mismatch top", DW'(res_fail), DW'(1));
    tick();
    tst_expect = ciph(tst_text, tst_key) ^ 128'h1;
    tick();
    request(128'h77, 128'h88);
    wait_valid();
    chk(res_fail == 1, "R4 single bit mismatch bottom", DW'(res_fail), DW'(1));
    tick();
    tst_expect = ciph(tst_text, tst_key);
    tick();

    // fault appearing only during the user run, then persisting
    request(128'hfeedface, 128'hc0ffee);
    gos = 1;
    while (gos < 2) begin tick(); if (core_go) gos++; end
    fault_mask = 128'h200;
    wait_valid();
    chk(res_fail == 0 && res_text == (ciph(128'hfeedface, 128'hc0ffee) ^ 128'h200),
        "R11 late fault passes through", res_text, ciph(128'hfeedface, 128'hc0ffee) ^ 128'h200);
    tick();
    request(128'hfeedface, 128'hc0ffee);
    wait_valid();
    chk(res_fail == 1 && res_text == '0, "R11 persistent fault caught next", DW'(res_fail), DW'(1));
    fault_mask = '0;
    tick(2);

    // start held high: starts during busy and done are ignored
    req_start = 1'b1;
    for (int i = 0; i < 40; i++) begin
      req_text = {4{32'(i * 32'h01010101)}};
      req_key  = {4{32'(i + 7)}};
      tick();
    end
    req_start = 1'b0;
    tick(20);
    summary();
  end
endmodule